// File: doc/BRIEF.md
# Debug Run Control Unit

This unit sits next to a processor core and decides, on behalf of an external debugger, whether the core may advance. It takes run, halt and single-step commands from the debugger, a halt request from a hardware breakpoint unit, and a strobe from the core saying it has just executed a break opcode. From these it drives the core's clock enable and fetch enable, and a status flag telling the debugger whether the core is halted. The peripheral clock enables pass straight through. Peripherals therefore keep running while the core is frozen, so a serial frame or timer that is already in progress completes.

The unit has three kinds of state: running, stopped and stepping. A step lets exactly one instruction into the core and waits for the core's retire strobe before it stops again. A break opcode seen during a step ends the step at once. A small cause field records what stopped the core, and it clears when the core is let go again. All commands and requests are single-cycle pulses sampled at the rising clock edge. Every output changes in the cycle after the edge that accepts a command.

Top module: `dbg_run_ctrl`

## Requirements
- R1: After reset the core runs. `halted`=0, `fetch_en`=1, `core_clk_en` equals `core_clk_req`, `halt_cause`=0 and `step_done`=0 (`core_clk_req` high).
- R2: While running, a pulse on `cmd_halt`, `bkpt_req` or `brk_op` stops the core at the next edge. From the following cycle `halted`=1, `fetch_en`=0 and `core_clk_en`=0.
- R3: `halt_cause` encodes the stop source as 0 none, 1 debugger, 2 breakpoint, 3 break opcode. When several sources arrive together, break opcode wins over breakpoint, and breakpoint wins over debugger halt.
- R4: A halt, breakpoint or break-opcode request that arrives while the core is stopped is ignored. The core stays halted and `halt_cause` keeps its value.
- R5: `cmd_run` while stopped releases the core at the next edge. `halted` goes to 0, `fetch_en` to 1 and `halt_cause` to 0.
- R6: `cmd_step` while stopped starts a step. In the first cycle `fetch_en`=1 and `core_clk_en`=1, and this cycle repeats while `core_clk_req` is low. After that `fetch_en`=0 while `core_clk_en` stays 1 until `retire` is seen. At that edge the core stops with `halt_cause`=1.
- R7: `step_done` is high for exactly the one cycle after the edge at which a step retires. It does not rise when a step ends for any other reason.
- R8: A `brk_op` during a step stops the core at the next edge with `halt_cause`=3.
- R9: `periph_clk_en` equals `periph_clk_req` bit for bit in every state, including halted and stepping.
- R10: `cmd_run` and `cmd_step` have no effect while running. When both arrive while stopped, the run command wins.
- R11: `retire` has no effect outside a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_run | input | 1 | Debugger resume pulse |
| cmd_halt | input | 1 | Debugger halt pulse |
| cmd_step | input | 1 | Debugger single-step pulse |
| bkpt_req | input | 1 | Halt request from breakpoint comparators |
| brk_op | input | 1 | Core executed the break opcode |
| retire | input | 1 | Core retired an instruction |
| core_clk_req | input | 1 | Functional core clock enable from clock control |
| periph_clk_req | input | NPERIPH | Functional peripheral clock enables |
| core_clk_en | output | 1 | Gated core clock enable |
| fetch_en | output | 1 | Permission to issue an instruction fetch |
| periph_clk_en | output | NPERIPH | Peripheral clock enables, never gated by debug |
| halted | output | 1 | Core stopped status |
| halt_cause | output | 2 | Stop source code |
| step_done | output | 1 | One-cycle pulse when a step retires |

## Verification
The hardest situations to reach from the ports are the step corners. These are a step whose fetch cycle is held back by a low `core_clk_req`, a retire that lands in the fetch cycle itself, and a break opcode that ends a step before any retire. The bench reaches each one by first halting the core. It then issues `cmd_step` with `core_clk_req`, `retire` or `brk_op` placed in the precise cycle after the step is accepted, and follows `fetch_en`, `halted`, `halt_cause` and `step_done` cycle by cycle.

// File: rtl/dbg_rc_pkg.sv
package dbg_rc_pkg;
  typedef enum logic [1:0] {
    RC_RUN       = 2'd0,
    RC_STOP      = 2'd1,
    RC_STEP_GO   = 2'd2,
    RC_STEP_WAIT = 2'd3
  } rc_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_DBG   = 2'd1,
    CAUSE_BKPT  = 2'd2,
    CAUSE_BRKOP = 2'd3
  } rc_cause_e;
endpackage

// File: rtl/dbg_rc_rst_sync.sv
module dbg_rc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("dbg_rc_rst_sync: STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[LAST-1:0], 1'b1};
  end

  assign srst_n = sync_q[LAST];
endmodule

// File: rtl/dbg_rc_halt_arb.sv
module dbg_rc_halt_arb
  import dbg_rc_pkg::*;
(
  input  logic      cmd_halt,
  input  logic      bkpt_req,
  input  logic      brk_op,
  output logic      req,
  output rc_cause_e cause
);
  // fixed priority: break opcode, breakpoint, debugger
  always_comb begin
    req   = cmd_halt | bkpt_req | brk_op;
    cause = CAUSE_NONE;
    if (brk_op)        cause = CAUSE_BRKOP;
    else if (bkpt_req) cause = CAUSE_BKPT;
    else if (cmd_halt) cause = CAUSE_DBG;
  end
endmodule

// File: rtl/dbg_rc_fsm.sv
module dbg_rc_fsm
  import dbg_rc_pkg::*;
#(
  parameter bit BOOT_HALTED = 1'b0
) (
  input  logic      clk,
  input  logic      srst_n,
  input  logic      cmd_run,
  input  logic      cmd_step,
  input  logic      halt_req,
  input  rc_cause_e halt_src,
  input  logic      brk_op,
  input  logic      retire,
  input  logic      core_clk_req,
  output rc_state_e state,
  output rc_cause_e cause,
  output logic      step_done
);
  rc_state_e rst_state;
  rc_cause_e rst_cause;

  generate
    if (BOOT_HALTED) begin : g_boot_stop
      assign rst_state = RC_STOP;
      assign rst_cause = CAUSE_DBG;
    end else begin : g_boot_run
      assign rst_state = RC_RUN;
      assign rst_cause = CAUSE_NONE;
    end
  endgenerate

  rc_state_e state_q, state_d;
  rc_cause_e cause_q, cause_d;
  logic      done_q, done_d;
  logic      in_step;

  assign in_step = (state_q == RC_STEP_GO) || (state_q == RC_STEP_WAIT);

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    done_d  = 1'b0;
    unique case (state_q)
      RC_RUN: begin
        if (halt_req) begin
          state_d = RC_STOP;
          cause_d = halt_src;
        end
      end
      RC_STOP: begin
        if (cmd_run) begin
          state_d = RC_RUN;
          cause_d = CAUSE_NONE;
        end else if (cmd_step) begin
          state_d = RC_STEP_GO;
          cause_d = CAUSE_NONE;
        end
      end
      default: begin
        if (brk_op) begin
          state_d = RC_STOP;
          cause_d = CAUSE_BRKOP;
        end else if (retire) begin
          state_d = RC_STOP;
          cause_d = CAUSE_DBG;
          done_d  = 1'b1;
        end else if (state_q == RC_STEP_GO && !core_clk_req) begin
          state_d = RC_STEP_GO;
        end else begin
          state_d = RC_STEP_WAIT;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= rst_state;
      cause_q <= rst_cause;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
      done_q  <= done_d & in_step;
    end
  end

  assign state     = state_q;
  assign cause     = cause_q;
  assign step_done = done_q;
endmodule

// File: rtl/dbg_rc_clk_ctrl.sv
module dbg_rc_clk_ctrl
  import dbg_rc_pkg::*;
#(
  parameter int NPERIPH = 4
) (
  input  rc_state_e          state,
  input  logic               core_clk_req,
  input  logic [NPERIPH-1:0] periph_clk_req,
  output logic               core_clk_en,
  output logic               fetch_en,
  output logic [NPERIPH-1:0] periph_clk_en,
  output logic               halted
);
  logic release_core;
  logic fetch_ok;

  always_comb begin
    release_core = (state != RC_STOP);
    fetch_ok     = (state == RC_RUN) || (state == RC_STEP_GO);
    halted       = (state == RC_STOP);
    core_clk_en  = core_clk_req & release_core;
    fetch_en     = core_clk_req & fetch_ok;
  end

  // peripheral enables are never qualified by debug state
  generate
    for (genvar i = 0; i < NPERIPH; i++) begin : g_periph
      assign periph_clk_en[i] = periph_clk_req[i];
    end
  endgenerate
endmodule

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl
  import dbg_rc_pkg::*;
#(
  parameter int NPERIPH         = 4,
  parameter int RST_SYNC_STAGES = 2,
  parameter bit BOOT_HALTED     = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_run,
  input  logic               cmd_halt,
  input  logic               cmd_step,
  input  logic               bkpt_req,
  input  logic               brk_op,
  input  logic               retire,
  input  logic               core_clk_req,
  input  logic [NPERIPH-1:0] periph_clk_req,
  output logic               core_clk_en,
  output logic               fetch_en,
  output logic [NPERIPH-1:0] periph_clk_en,
  output logic               halted,
  output logic [1:0]         halt_cause,
  output logic               step_done
);
  logic      srst_n;
  logic      halt_req;
  rc_cause_e halt_src;
  rc_state_e state;
  rc_cause_e cause;

  dbg_rc_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  dbg_rc_halt_arb u_arb (
    .cmd_halt (cmd_halt),
    .bkpt_req (bkpt_req),
    .brk_op   (brk_op),
    .req      (halt_req),
    .cause    (halt_src)
  );

  dbg_rc_fsm #(.BOOT_HALTED(BOOT_HALTED)) u_fsm (
    .clk          (clk),
    .srst_n       (srst_n),
    .cmd_run      (cmd_run),
    .cmd_step     (cmd_step),
    .halt_req     (halt_req),
    .halt_src     (halt_src),
    .brk_op       (brk_op),
    .retire       (retire),
    .core_clk_req (core_clk_req),
    .state        (state),
    .cause        (cause),
    .step_done    (step_done)
  );

  dbg_rc_clk_ctrl #(.NPERIPH(NPERIPH)) u_clk (
    .state          (state),
    .core_clk_req   (core_clk_req),
    .periph_clk_req (periph_clk_req),
    .core_clk_en    (core_clk_en),
    .fetch_en       (fetch_en),
    .periph_clk_en  (periph_clk_en),
    .halted         (halted)
  );

  assign halt_cause = cause;
endmodule

// File: rtl/dbg_run_ctrl_chk.sv
module dbg_run_ctrl_chk
  import dbg_rc_pkg::*;
(
  input logic       clk,
  input logic       srst_n,
  input logic [1:0] state,
  input logic       cmd_run,
  input logic       cmd_halt,
  input logic       cmd_step,
  input logic       bkpt_req,
  input logic       brk_op,
  input logic       retire,
  input logic       core_clk_en,
  input logic       fetch_en,
  input logic       halted,
  input logic [1:0] halt_cause,
  input logic       step_done
);
  logic running;
  logic stepping;
  assign running  = (state == RC_RUN);
  assign stepping = (state == RC_STEP_GO) || (state == RC_STEP_WAIT);

  assert_halt_stops_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (running && (cmd_halt || bkpt_req || brk_op)) |=> halted);

  assert_frozen_R2: assert property (@(posedge clk) disable iff (!srst_n)
    halted |-> (!fetch_en && !core_clk_en));

  assert_brkop_cause_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (running && brk_op) |=> (halt_cause == 2'd3));

  assert_stop_ignores_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (halted && !cmd_run && !cmd_step) |=> (halted && $stable(halt_cause)));

  assert_resume_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (halted && cmd_run) |=> (!halted && halt_cause == 2'd0));

  assert_step_start_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (halted && cmd_step && !cmd_run) |=> (state == RC_STEP_GO));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!srst_n)
    step_done |=> !step_done);

  assert_done_after_retire_R7: assert property (@(posedge clk) disable iff (!srst_n)
    step_done |-> (halted && $past(retire)));

  assert_step_brk_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (stepping && brk_op) |=> (halted && halt_cause == 2'd3));
endmodule

bind dbg_run_ctrl dbg_run_ctrl_chk u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .state       (state),
  .cmd_run     (cmd_run),
  .cmd_halt    (cmd_halt),
  .cmd_step    (cmd_step),
  .bkpt_req    (bkpt_req),
  .brk_op      (brk_op),
  .retire      (retire),
  .core_clk_en (core_clk_en),
  .fetch_en    (fetch_en),
  .halted      (halted),
  .halt_cause  (halt_cause),
  .step_done   (step_done)
);

// File: tb/dbg_run_ctrl_test.sv
module dbg_run_ctrl_test;
  localparam int NP = 4;

  logic          clk;
  logic          rst_n;
  logic          cmd_run, cmd_halt, cmd_step, bkpt_req, brk_op, retire;
  logic          core_clk_req;
  logic [NP-1:0] periph_clk_req;
  logic          core_clk_en, fetch_en, halted, step_done;
  logic [NP-1:0] periph_clk_en;
  logic [1:0]    halt_cause;

  int tests = 0;
  int fails = 0;

  dbg_run_ctrl #(.NPERIPH(NP)) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_run        (cmd_run),
    .cmd_halt       (cmd_halt),
    .cmd_step       (cmd_step),
    .bkpt_req       (bkpt_req),
    .brk_op         (brk_op),
    .retire         (retire),
    .core_clk_req   (core_clk_req),
    .periph_clk_req (periph_clk_req),
    .core_clk_en    (core_clk_en),
    .fetch_en       (fetch_en),
    .periph_clk_en  (periph_clk_en),
    .halted         (halted),
    .halt_cause     (halt_cause),
    .step_done      (step_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // advance one edge, then settle away from it
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    cmd_run = 0; cmd_halt = 0; cmd_step = 0;
    bkpt_req = 0; brk_op = 0; retire = 0;
  endtask

  // status: halted, fetch, core enable, cause
  task automatic expect_state(input string req, input int h, input int f, input int c, input int cause);
    check(req, "halted", int'(halted), h);
    check(req, "fetch_en", int'(fetch_en), f);
    check(req, "core_clk_en", int'(core_clk_en), c);
    check(req, "halt_cause", int'(halt_cause), cause);
  endtask

  task automatic do_halt();
    cmd_halt = 1; tick(); cmd_halt = 0;
  endtask

  task automatic do_run();
    cmd_run = 1; tick(); cmd_run = 0;
  endtask

  task automatic t_reset();
    expect_state("R1", 0, 1, 1, 0);
    check("R1", "step_done", int'(step_done), 0);
  endtask

  task automatic t_halt_sources();
    // debugger halt
    do_halt();
    expect_state("R2", 1, 0, 0, 1);
    // other requests while stopped are ignored
    bkpt_req = 1; brk_op = 1; cmd_halt = 1; tick(); idle_inputs();
    expect_state("R4", 1, 0, 0, 1);
    tick();
    expect_state("R4", 1, 0, 0, 1);
    do_run();
    expect_state("R5", 0, 1, 1, 0);
    // breakpoint
    bkpt_req = 1; tick(); bkpt_req = 0;
    expect_state("R2", 1, 0, 0, 2);
    do_run();
    expect_state("R5", 0, 1, 1, 0);
    // break opcode
    brk_op = 1; tick(); brk_op = 0;
    expect_state("R2", 1, 0, 0, 3);
    do_run();
  endtask

  task automatic t_priority();
    cmd_halt = 1; bkpt_req = 1; brk_op = 1; tick(); idle_inputs();
    check("R3", "all sources cause", int'(halt_cause), 3);
    do_run();
    cmd_halt = 1; bkpt_req = 1; tick(); idle_inputs();
    check("R3", "bkpt over debugger cause", int'(halt_cause), 2);
    do_run();
  endtask

  task automatic t_step_basic();
    do_halt();
    cmd_step = 1; tick(); cmd_step = 0;
    expect_state("R6", 0, 1, 1, 0);
    tick();
    expect_state("R6", 0, 0, 1, 0);
    tick();
    expect_state("R6", 0, 0, 1, 0);
    check("R7", "no done before retire", int'(step_done), 0);
    retire = 1; tick(); retire = 0;
    expect_state("R6", 1, 0, 0, 1);
    check("R7", "done after retire", int'(step_done), 1);
    tick();
    check("R7", "done one cycle", int'(step_done), 0);
    check("R6", "stays halted", int'(halted), 1);
  endtask

  task automatic t_step_fast_retire();
    // stopped from previous task; retire lands in the fetch cycle
    cmd_step = 1; tick(); cmd_step = 0;
    retire = 1; tick(); retire = 0;
    expect_state("R6", 1, 0, 0, 1);
    check("R7", "done fast retire", int'(step_done), 1);
    tick();
  endtask

  task automatic t_step_brk();
    cmd_step = 1; tick(); cmd_step = 0;
    tick();
    brk_op = 1; tick(); brk_op = 0;
    expect_state("R8", 1, 0, 0, 3);
    check("R7", "no done on break", int'(step_done), 0);
    tick();
    check("R7", "still no done", int'(step_done), 0);
  endtask

  task automatic t_step_gated();
    core_clk_req = 0;
    cmd_step = 1; tick(); cmd_step = 0;
    check("R6", "fetch gated", int'(fetch_en), 0);
    tick();
    check("R6", "gated stays unhalted", int'(halted), 0);
    core_clk_req = 1; #1;
    check("R6", "fetch held for enable", int'(fetch_en), 1);
    tick();
    check("R6", "fetch only once", int'(fetch_en), 0);
    retire = 1; tick(); retire = 0;
    expect_state("R6", 1, 0, 0, 1);
    tick();
  endtask

  task automatic t_ignored();
    // stopped: retire does nothing
    retire = 1; tick(); retire = 0;
    expect_state("R11", 1, 0, 0, 1);
    check("R11", "no done", int'(step_done), 0);
    // run beats step
    cmd_run = 1; cmd_step = 1; tick(); idle_inputs();
    expect_state("R10", 0, 1, 1, 0);
    tick();
    check("R10", "run not step fetch", int'(fetch_en), 1);
    // running: run, step and retire are ignored
    cmd_run = 1; cmd_step = 1; retire = 1; tick(); idle_inputs();
    expect_state("R10", 0, 1, 1, 0);
    tick();
    expect_state("R11", 0, 1, 1, 0);
    check("R11", "no done running", int'(step_done), 0);
  endtask

  task automatic t_periph();
    periph_clk_req = 4'b1010; #1;
    check("R9", "periph run", int'(periph_clk_en), 4'b1010);
    do_halt();
    check("R9", "periph halted", int'(periph_clk_en), 4'b1010);
    periph_clk_req = 4'b0111; #1;
    check("R9", "periph halted change", int'(periph_clk_en), 4'b0111);
    cmd_step = 1; tick(); cmd_step = 0;
    tick();
    check("R9", "periph stepping", int'(periph_clk_en), 4'b0111);
    retire = 1; tick(); retire = 0;
    do_run();
    periph_clk_req = '1;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    core_clk_req = 1;
    periph_clk_req = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) tick();
    t_reset();
    t_halt_sources();
    t_priority();
    t_step_basic();
    t_step_fast_retire();
    t_step_brk();
    t_step_gated();
    t_ignored();
    t_periph();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule